// File: doc/BRIEF.md
# Two-Stage System Watchdog Timer

This block guards a system against software that stops making progress. A down-counter steps once per prescaled tick (a parameterised divider of the system clock, around 0.6 s per tick at the default setting). When the count runs out the first time, the block raises a timeout status flag and, if enabled, an interrupt request. It then reloads and arms a second stage. If the count runs out again before software reloads it, the block issues a one-cycle system reset request and records that fact in a sticky flag that survives the resulting system reset.

Software drives the block through a small synchronous register bus. It can halt or run the countdown, program the timeout, kick the timer by writing to a reload address, enable the interrupt and clear status bits by writing ones. A no-reboot bit, which a lock input can hold on, turns the reset request off while still letting the expiries be recorded. Two resets come in: a system reset that restores every register except the sticky flag, and a power-on reset that clears everything.

Top module: `wdt2_watchdog`

Register addresses (3-bit): 0 control (bit 0 halt, bit 1 no-reboot), 1 reload, 2 timeout value, 3 live count (read only), 4 timeout status (bit 0), 5 second-stage status (bit 0 second timeout, bit 1 boot flag), 6 interrupt enable (bit 0). A read returns its data on `bus_rdata_o` with `bus_rvalid_o` high one cycle after `bus_ren_i`.

## Requirements
- R1: After either reset, control reads 1 (halted, no-reboot clear with the lock input low), the count and the timeout value read TMR_DEF, timeout status and interrupt enable read 0, and irq_o and sys_rst_req_o are low.
- R2: While the halt bit (control bit 0) is 1, the live count does not change.
- R3: A write of any data to the reload address loads the count from the stored timeout value and restarts the tick divider. The written data has no effect.
- R4: Writing the timeout value does not change the live count until the next reload.
- R5: A written timeout below TMR_MIN is stored as TMR_MIN, and one above 2^TMR_W-1 is stored as 2^TMR_W-1. Other values are stored unchanged.
- R6: With a count N loaded and the block running, the count runs out on the (N+1)th tick. The first run-out sets timeout status bit 0, reloads the count and asserts no reset request.
- R7: irq_o is high one cycle after timeout status and interrupt enable bit 0 are both 1. With enable bit 0 clear, status is still set but irq_o stays low.
- R8: Status bits are set only by expiries. Writing 1 to a bit clears it, and writing 0 leaves it unchanged.
- R9: A second run-out without a reload in between drives sys_rst_req_o high for exactly one cycle and sets second-stage bit 0.
- R10: A reload between the first and second run-outs disarms the second stage, so the next run-out counts as a first one and no reset request follows.
- R11: When the no-reboot bit (control bit 1) or reboot_lock_i is 1, a second run-out sets second-stage bit 0 and boot bit 1 but produces no reset request. Control bit 1 reads 1 while the lock input is high.
- R12: The second-timeout flag keeps its value through rst_i and is cleared only by por_i or by software.
- R13: The two second-stage flags are cleared by separate writes. A write with bit 0 set clears only the second-timeout flag. The boot flag is cleared only by a write with bit 0 clear and bit 1 set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous system reset, active high; keeps the second-timeout flag |
| por_i | input | 1 | Synchronous power-on reset, active high; clears everything |
| bus_wen_i | input | 1 | Register write strobe |
| bus_ren_i | input | 1 | Register read strobe |
| bus_addr_i | input | 3 | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid, one cycle after the read strobe |
| reboot_lock_i | input | 1 | Holds the no-reboot function on |
| irq_o | output | 1 | Interrupt request after a timeout, registered |
| sys_rst_req_o | output | 1 | One-cycle system reset request after the second run-out |

## Verification
The hardest case to reach is the second run-out, because the bench has to let a full period pass with no reload after the first. Only then can it show that the reset request lasts one cycle and that the sticky flag survives the system reset which that request would cause. The stimulus runs the block with a short divider and a small timeout. It counts cycles from the unhalt or reload write so that every read lands just before or just after a computed expiry edge. It then asserts rst_i itself to play the part of the reset circuit, and repeats the double expiry with the no-reboot bit set and again with the lock input set.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_RELOAD = 3'd1,
    A_TIMER  = 3'd2,
    A_COUNT  = 3'd3,
    A_STAT1  = 3'd4,
    A_STAT2  = 3'd5,
    A_IEN    = 3'd6
  } wdt2_addr_e;

  localparam int CTRL_HALT_BIT  = 0;
  localparam int CTRL_NR_BIT    = 1;
  localparam int ST2_SECOND_BIT = 0;
  localparam int ST2_BOOT_BIT   = 1;
endpackage

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int DIV = 60_000_000
) (
  input  logic clk_i,
  input  logic clr_i,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

  generate
    if (DIV == 1) begin : g_direct
      assign tick_o = run_i;
    end else begin : g_div
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q;

      always_ff @(posedge clk_i) begin
        if (clr_i || !run_i) pre_q <= '0;
        else if (pre_q == LAST) pre_q <= '0;
        else pre_q <= pre_q + 1'b1;
      end

      assign tick_o = run_i && !clr_i && (pre_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/wdt2_countdown.sv
module wdt2_countdown #(
  parameter int TMR_W   = 10,
  parameter int TMR_DEF = 16
) (
  input  logic             clk_i,
  input  logic             rst_i,
  input  logic             por_i,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [TMR_W-1:0] tmr_val_i,
  input  logic             no_reboot_i,
  output logic [TMR_W-1:0] cnt_o,
  output logic             first_exp_o,
  output logic             second_exp_o,
  output logic             rst_req_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             armed_q;
  logic             rst_q;
  logic             run_out;

  assign run_out      = tick_i && !reload_i && (cnt_q == '0);
  assign first_exp_o  = run_out && !armed_q;
  assign second_exp_o = run_out && armed_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || por_i) begin
      cnt_q   <= TMR_W'(TMR_DEF);
      armed_q <= 1'b0;
      rst_q   <= 1'b0;
    end else begin
      rst_q <= 1'b0;
      if (reload_i) begin
        cnt_q   <= tmr_val_i;
        armed_q <= 1'b0;
      end else if (tick_i) begin
        if (cnt_q == '0) begin
          cnt_q <= tmr_val_i;
          if (!armed_q) begin
            armed_q <= 1'b1;
          end else begin
            armed_q <= 1'b0;
            rst_q   <= !no_reboot_i;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  assign cnt_o     = cnt_q;
  assign rst_req_o = rst_q;

  // R9: reset request never lasts more than one cycle
  a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    rst_q |=> !rst_q);

  // R11: no reset request when the no-reboot function was active
  a_r11_no_reboot: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    rst_q |-> !$past(no_reboot_i));

  // R10: a reset request needs a second-stage expiry with no reload in between
  a_r10_needs_arm: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    rst_q |-> $past(second_exp_o));
endmodule

// File: rtl/wdt2_regfile.sv
module wdt2_regfile
  import wdt2_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int TMR_W   = 10,
  parameter int TMR_MIN = 4,
  parameter int TMR_DEF = 16
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              por_i,
  input  logic              wen_i,
  input  logic              ren_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rvalid_o,
  input  logic              lock_i,
  input  logic              first_exp_i,
  input  logic              second_exp_i,
  input  logic [TMR_W-1:0]  cnt_i,
  output logic              halt_o,
  output logic              no_reboot_o,
  output logic              ien_o,
  output logic              sts_to_o,
  output logic              reload_o,
  output logic [TMR_W-1:0]  tmr_val_o
);
  localparam int TMR_MAX = (1 << TMR_W) - 1;
  localparam logic [DATA_W-1:0] MIN_D = DATA_W'(TMR_MIN);
  localparam logic [DATA_W-1:0] MAX_D = DATA_W'(TMR_MAX);

  logic             halt_q, nr_q, ien_q;
  logic             sts_to_q, sts_second_q, sts_boot_q;
  logic [TMR_W-1:0] tmr_q;
  logic             wr_ctrl, wr_timer, wr_stat1, wr_stat2, wr_ien;
  logic             nr_eff;
  logic [DATA_W-1:0] rd_mux;

  function automatic logic [TMR_W-1:0] clamp_tmr(input logic [DATA_W-1:0] v);
    if (v < MIN_D)      return TMR_W'(MIN_D);
    else if (v > MAX_D) return TMR_W'(MAX_D);
    else                return TMR_W'(v);
  endfunction

  assign wr_ctrl  = wen_i && (addr_i == A_CTRL);
  assign reload_o = wen_i && (addr_i == A_RELOAD);
  assign wr_timer = wen_i && (addr_i == A_TIMER);
  assign wr_stat1 = wen_i && (addr_i == A_STAT1);
  assign wr_stat2 = wen_i && (addr_i == A_STAT2);
  assign wr_ien   = wen_i && (addr_i == A_IEN);
  assign nr_eff   = nr_q || lock_i;

  // control, timeout value, enable, timeout status and boot flag
  always_ff @(posedge clk_i) begin
    if (rst_i || por_i) begin
      halt_q     <= 1'b1;
      nr_q       <= 1'b0;
      ien_q      <= 1'b0;
      tmr_q      <= TMR_W'(TMR_DEF);
      sts_to_q   <= 1'b0;
      sts_boot_q <= 1'b0;
    end else begin
      if (wr_ctrl) begin
        halt_q <= wdata_i[CTRL_HALT_BIT];
        nr_q   <= wdata_i[CTRL_NR_BIT];
      end
      if (wr_ien)   ien_q <= wdata_i[0];
      if (wr_timer) tmr_q <= clamp_tmr(wdata_i);

      if (first_exp_i || second_exp_i) sts_to_q <= 1'b1;
      else if (wr_stat1 && wdata_i[0]) sts_to_q <= 1'b0;

      if (second_exp_i && nr_eff) sts_boot_q <= 1'b1;
      else if (wr_stat2 && !wdata_i[ST2_SECOND_BIT] && wdata_i[ST2_BOOT_BIT])
        sts_boot_q <= 1'b0;
    end
  end

  // sticky second-timeout flag: only power-on reset or software clears it
  always_ff @(posedge clk_i) begin
    if (por_i) sts_second_q <= 1'b0;
    else if (second_exp_i) sts_second_q <= 1'b1;
    else if (wr_stat2 && wdata_i[ST2_SECOND_BIT]) sts_second_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_CTRL: begin
        rd_mux[CTRL_HALT_BIT] = halt_q;
        rd_mux[CTRL_NR_BIT]   = nr_eff;
      end
      A_TIMER: rd_mux = DATA_W'(tmr_q);
      A_COUNT: rd_mux = DATA_W'(cnt_i);
      A_STAT1: rd_mux[0] = sts_to_q;
      A_STAT2: begin
        rd_mux[ST2_SECOND_BIT] = sts_second_q;
        rd_mux[ST2_BOOT_BIT]   = sts_boot_q;
      end
      A_IEN:   rd_mux[0] = ien_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || por_i) begin
      rdata_o  <= '0;
      rvalid_o <= 1'b0;
    end else begin
      rvalid_o <= ren_i;
      if (ren_i) rdata_o <= rd_mux;
    end
  end

  assign halt_o      = halt_q;
  assign no_reboot_o = nr_eff;
  assign ien_o       = ien_q;
  assign sts_to_o    = sts_to_q;
  assign tmr_val_o   = tmr_q;

  // R8: timeout status only drops through a write of one
  a_r8_w1c_only: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    $fell(sts_to_q) |-> $past(wr_stat1 && wdata_i[0]));

  // R13: boot flag drops only through its own write
  a_r13_split_clear: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    $fell(sts_boot_q) |-> $past(wr_stat2 && !wdata_i[ST2_SECOND_BIT]));

  // R5: stored timeout always within the legal range
  a_r5_range: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    (DATA_W'(tmr_q) >= MIN_D) && (DATA_W'(tmr_q) <= MAX_D));

  // R12: system reset keeps the second-timeout flag
  a_r12_sticky: assert property (@(posedge clk_i) disable iff (por_i)
    (rst_i && sts_second_q && !wr_stat2) |=> sts_second_q);
endmodule

// File: rtl/wdt2_watchdog.sv
module wdt2_watchdog
  import wdt2_pkg::*;
#(
  parameter int DATA_W   = 16,
  parameter int TMR_W    = 10,
  parameter int TMR_MIN  = 4,
  parameter int TMR_DEF  = 16,
  parameter int TICK_DIV = 60_000_000
) (
  input  logic              clk_i,
  input  logic              rst_i,
  input  logic              por_i,
  input  logic              bus_wen_i,
  input  logic              bus_ren_i,
  input  logic [2:0]        bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic              bus_rvalid_o,
  input  logic              reboot_lock_i,
  output logic              irq_o,
  output logic              sys_rst_req_o
);
  logic             halt, no_reboot, ien, sts_to, reload, tick;
  logic             first_exp, second_exp;
  logic [TMR_W-1:0] tmr_val, cnt;
  logic             irq_q;

  wdt2_regfile #(
    .DATA_W(DATA_W), .TMR_W(TMR_W), .TMR_MIN(TMR_MIN), .TMR_DEF(TMR_DEF)
  ) u_regs (
    .clk_i(clk_i), .rst_i(rst_i), .por_i(por_i),
    .wen_i(bus_wen_i), .ren_i(bus_ren_i), .addr_i(bus_addr_i),
    .wdata_i(bus_wdata_i), .rdata_o(bus_rdata_o), .rvalid_o(bus_rvalid_o),
    .lock_i(reboot_lock_i), .first_exp_i(first_exp), .second_exp_i(second_exp),
    .cnt_i(cnt), .halt_o(halt), .no_reboot_o(no_reboot), .ien_o(ien),
    .sts_to_o(sts_to), .reload_o(reload), .tmr_val_o(tmr_val)
  );

  wdt2_prescaler #(.DIV(TICK_DIV)) u_pre (
    .clk_i(clk_i), .clr_i(rst_i || por_i || reload), .run_i(!halt), .tick_o(tick)
  );

  wdt2_countdown #(.TMR_W(TMR_W), .TMR_DEF(TMR_DEF)) u_cnt (
    .clk_i(clk_i), .rst_i(rst_i), .por_i(por_i), .tick_i(tick),
    .reload_i(reload), .tmr_val_i(tmr_val), .no_reboot_i(no_reboot),
    .cnt_o(cnt), .first_exp_o(first_exp), .second_exp_o(second_exp),
    .rst_req_o(sys_rst_req_o)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i || por_i) irq_q <= 1'b0;
    else irq_q <= sts_to && ien;
  end
  assign irq_o = irq_q;

  // R2: halted counter holds its value unless reloaded
  a_r2_halt_freeze: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    (halt && !reload) |=> $stable(cnt));

  // R7: interrupt requires the enable
  a_r7_irq_gate: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    irq_o |-> $past(ien));

  // R6: a first expiry never requests a reset in the next cycle
  a_r6_first_quiet: assert property (@(posedge clk_i) disable iff (rst_i || por_i)
    first_exp |=> !sys_rst_req_o);
endmodule

// File: tb/wdt2_watchdog_tb_top.sv
module wdt2_watchdog_tb_top;
  localparam int DATA_W = 16;
  localparam int DIV    = 4;

  logic              clk = 1'b0;
  logic              rst_i = 1'b1, por_i = 1'b1;
  logic              wen = 1'b0, ren = 1'b0;
  logic [2:0]        addr = '0;
  logic [DATA_W-1:0] wdata = '0;
  logic [DATA_W-1:0] rdata;
  logic              rvalid;
  logic              lock = 1'b0;
  logic              irq, sysrst;

  int n_checks = 0;
  int n_fail   = 0;
  int rst_seen = 0;
  int cur_w    = 0;
  int max_w    = 0;
  bit done     = 0;

  logic [DATA_W-1:0] exp_q[$];
  string             tag_q[$];

  always #5 clk = ~clk;

  wdt2_watchdog #(
    .DATA_W(DATA_W), .TMR_W(8), .TMR_MIN(2), .TMR_DEF(8), .TICK_DIV(DIV)
  ) dut_i (
    .clk_i(clk), .rst_i(rst_i), .por_i(por_i),
    .bus_wen_i(wen), .bus_ren_i(ren), .bus_addr_i(addr), .bus_wdata_i(wdata),
    .bus_rdata_o(rdata), .bus_rvalid_o(rvalid),
    .reboot_lock_i(lock), .irq_o(irq), .sys_rst_req_o(sysrst)
  );

  // monitor: read scoreboard and reset-pulse tracking
  always @(negedge clk) begin
    if (rvalid) begin
      n_checks++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data: actual %0h expected none", rdata);
      end else begin
        logic [DATA_W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_fail++;
          $display("FAIL %s: actual %0h expected %0h", t, rdata, e);
        end
      end
    end
    if (sysrst) begin
      rst_seen++;
      cur_w++;
      if (cur_w > max_w) max_w = cur_w;
    end else begin
      cur_w = 0;
    end
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [DATA_W-1:0] d);
    wen = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [DATA_W-1:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    ren = 1'b1; addr = a;
    @(negedge clk);
    ren = 1'b0;
  endtask

  task automatic chk(input bit ok, input string t, input int act, input int e);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", t, act, e);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_i = 1'b0; por_i = 1'b0;
    wait_n(1);
    // R1 reset defaults
    rd(3'd0, 16'd1, "R1 control");
    rd(3'd3, 16'd8, "R1 count");
    rd(3'd2, 16'd8, "R1 timer");
    rd(3'd4, 16'd0, "R1 status");
    rd(3'd6, 16'd0, "R1 enable");
    chk(irq == 1'b0 && sysrst == 1'b0, "R1 outputs", int'(irq | sysrst), 0);

    // R5 clamping
    wr(3'd2, 16'd1);      rd(3'd2, 16'd2,   "R5 below min");
    wr(3'd2, 16'hFFFF);   rd(3'd2, 16'd255, "R5 above max");
    wr(3'd2, 16'd20);     rd(3'd2, 16'd20,  "R5 in range");
    // R4 no effect before reload
    rd(3'd3, 16'd8, "R4 count unchanged");
    // R3 reload, data ignored
    wr(3'd1, 16'hABCD);   rd(3'd3, 16'd20, "R3 reload");
    // R2 halt freezes
    wait_n(50);
    rd(3'd3, 16'd20, "R2 halted count");

    // R6/R7 first expiry with interrupt disabled; period (5+1)*4 = 24
    wr(3'd2, 16'd5);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd0);                  // unhalt at edge e
    wait_n(20);                       // e+20.5
    chk(irq == 1'b0, "R6 irq before expiry", int'(irq), 0);
    rd(3'd4, 16'd0, "R6 status before expiry");
    wait_n(5);                        // e+26.5
    rd(3'd4, 16'd1, "R6 status after expiry");
    chk(irq == 1'b0, "R7 gated irq", int'(irq), 0);
    chk(rst_seen == 0, "R6 no reset on first", rst_seen, 0);
    // R8 write-one-to-clear
    wr(3'd4, 16'd0);  rd(3'd4, 16'd1, "R8 write zero keeps");
    wr(3'd4, 16'd1);  rd(3'd4, 16'd0, "R8 write one clears");
    // R10 reload disarms; next expiry at +24 is a first one
    wr(3'd1, 16'd0);
    wait_n(26);
    chk(rst_seen == 0, "R10 no reset after disarm", rst_seen, 0);
    rd(3'd4, 16'd1, "R10 first again");
    rd(3'd5, 16'd0, "R10 no second flag");
    // R7 enable
    wr(3'd6, 16'd1);
    wait_n(1);
    chk(irq == 1'b1, "R7 irq enabled", int'(irq), 1);
    wr(3'd4, 16'd1);
    wait_n(1);
    chk(irq == 1'b0, "R7 irq after clear", int'(irq), 0);
    // R9 second expiry
    wait_n(20);
    chk(rst_seen == 1, "R9 reset pulse count", rst_seen, 1);
    chk(max_w == 1, "R9 reset pulse width", max_w, 1);
    rd(3'd5, 16'd1, "R9 second flag");

    // R12 system reset keeps sticky flag
    rst_i = 1'b1;
    wait_n(2);
    rst_i = 1'b0;
    wait_n(1);
    rd(3'd5, 16'd1, "R12 sticky after reset");
    rd(3'd0, 16'd1, "R12 control default");
    rd(3'd2, 16'd8, "R12 timer default");
    rd(3'd6, 16'd0, "R12 enable default");

    // R11 no-reboot bit; period (2+1)*4 = 12, two expiries within 30
    wr(3'd2, 16'd2);
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd2);
    wait_n(30);
    wr(3'd0, 16'd3);
    chk(rst_seen == 1, "R11 no reset with bit", rst_seen, 1);
    rd(3'd5, 16'd3, "R11 boot and second");
    rd(3'd0, 16'd3, "R11 control readback");

    // R13 separate clears
    wr(3'd5, 16'd3);  rd(3'd5, 16'd2, "R13 both bits clears second only");
    wr(3'd5, 16'd2);  rd(3'd5, 16'd0, "R13 boot cleared alone");

    // R11 lock input
    lock = 1'b1;
    wr(3'd0, 16'd1);
    rd(3'd0, 16'd3, "R11 lock forces bit");
    wr(3'd1, 16'd0);
    wr(3'd0, 16'd0);
    wait_n(30);
    wr(3'd0, 16'd1);
    chk(rst_seen == 1, "R11 no reset with lock", rst_seen, 1);
    rd(3'd5, 16'd3, "R11 lock flags");
    lock = 1'b0;

    // R12 power-on reset clears sticky flag
    por_i = 1'b1;
    wait_n(2);
    por_i = 1'b0;
    wait_n(1);
    rd(3'd5, 16'd0, "R12 cleared by power-on");
    rd(3'd0, 16'd1, "R1 control after power-on");
    wait_n(3);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule